// File: doc/BRIEF.md
# Load Result Align and Extend Stage

This block is the last stage of a load in a processor's memory pipeline. It takes the raw 64-bit word read from the data cache and uses the low address bits to move the wanted bytes down to bit 0. It then widens byte, halfword and word loads to the full datapath width, with sign or zero fill chosen by the load. If an unprivileged access touches data marked as privileged, the result is forced to zero.

The stage also decides whether the result may be written back. A result is valid only when the cache hit, the address was aligned to the access size, the translation did not miss, and no pending store holds a lock on the address. When a load fails, a four-bit cause vector tells the refill logic why. The stage has one register and a flush input that cancels the result it is producing.

Top module: `lsx_top`

## Requirements
- R1: The selected data is the cache word shifted right by 8 times `addrLow` bits before extension.
- R2: `size` is encoded 00=byte, 01=halfword, 10=word, 11=doubleword. For the first three sizes, the upper bits of `outData` are copies of the top bit of the selected field when `signedLd`=1 and zeros when `signedLd`=0.
- R3: A doubleword load (size 11) with `addrLow`=0 returns the cache word unchanged, whatever `signedLd` is.
- R4: When `userMode`=1 and `privData`=1, `outData` is all zeros. This condition does not change `outValid` or `failCause`.
- R5: A load is misaligned when `addrLow` is not a multiple of its size in bytes. Byte loads are never misaligned.
- R6: `failCause` bit 0 = cache miss (`cacheHit`=0), bit 1 = misaligned, bit 2 = `tlbMiss`, bit 3 = `storeLock`. All bits are zero when no load was accepted in the previous cycle.
- R7: `outValid` is 1 exactly when a load was accepted in the previous cycle and all four cause bits are zero.
- R8: Outputs follow an accepted load (`inValid`=1, `flush`=0) by one clock. `outLoad` shows that a load was accepted in the previous cycle.
- R9: `flush`=1 at a clock edge clears `outLoad`, `outValid` and `failCause` after that edge, even if `inValid` is 1.
- R10: After reset, `outLoad`, `outValid`, `failCause` and `outData` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Cancel the load being captured |
| inValid | input | 1 | A load is presented this cycle |
| addrLow | input | 3 | Byte offset of the load within the cache word |
| size | input | 2 | Access size code |
| signedLd | input | 1 | 1 = sign-extend, 0 = zero-extend |
| cacheWord | input | 64 | Raw word read from the cache |
| cacheHit | input | 1 | The cache lookup hit |
| tlbMiss | input | 1 | The address translation missed |
| storeLock | input | 1 | The address is locked by a pending store |
| userMode | input | 1 | The access runs unprivileged |
| privData | input | 1 | The data is marked privileged |
| outLoad | output | 1 | A load was accepted in the previous cycle |
| outValid | output | 1 | The result may be written back |
| outData | output | 64 | Aligned, extended result |
| failCause | output | 4 | Reasons the load failed |

## Verification
The bench builds the block with its default 64-bit datapath, which gives eight byte offsets. All offsets, all four size codes and both extension modes can be reached with every combination of cause inputs. Random stimulus covers every misaligned offset for each size and lets several causes occur together. Directed cases cover a negative top bit at each field width, the privilege zeroing, and a flush that arrives together with a valid load.

// File: rtl/lsx_pkg.sv
package lsx_pkg;
  localparam logic [1:0] SZ_BYTE  = 2'b00;
  localparam logic [1:0] SZ_HALF  = 2'b01;
  localparam logic [1:0] SZ_WORD  = 2'b10;
  localparam logic [1:0] SZ_DWORD = 2'b11;

  localparam int CAUSE_W     = 4;
  localparam int CAUSE_MISS  = 0;
  localparam int CAUSE_ALIGN = 1;
  localparam int CAUSE_TLB   = 2;
  localparam int CAUSE_LOCK  = 3;

  typedef struct packed {
    logic capture;
    logic clear;
  } strobe_t;
endpackage

// File: rtl/lsx_datapath.sv
module lsx_datapath #(
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  lsx_pkg::strobe_t     stb,
  input  logic [OFF_W-1:0]     offset,
  input  logic [1:0]           size,
  input  logic                 signedLd,
  input  logic                 zeroData,
  input  logic [DATA_W-1:0]    word,
  output logic [DATA_W-1:0]    dataQ
);
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] extended [4];
  logic [DATA_W-1:0] result;

  assign shifted = word >> {offset, 3'b000};

  for (genvar g = 0; g < 4; g++) begin : g_ext
    localparam int FIELD_W = 8 << g;
    if (FIELD_W < DATA_W) begin : g_fill
      assign extended[g] = {{(DATA_W-FIELD_W){signedLd & shifted[FIELD_W-1]}},
                            shifted[FIELD_W-1:0]};
    end else begin : g_pass
      assign extended[g] = shifted;
    end
  end

  assign result = zeroData ? '0 : extended[size];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataQ <= '0;
    else if (stb.capture) dataQ <= result;
  end

  // R4
  priv_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && zeroData) |=> (dataQ == '0));

  // R3
  dword_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && !zeroData && size == lsx_pkg::SZ_DWORD && offset == '0)
      |=> (dataQ == $past(word)));
endmodule

// File: rtl/lsx_control.sv
module lsx_control #(
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  input  logic                          flush,
  input  logic [OFF_W-1:0]              offset,
  input  logic [1:0]                    size,
  input  logic                          cacheHit,
  input  logic                          tlbMiss,
  input  logic                          storeLock,
  input  logic                          userMode,
  input  logic                          privData,
  output lsx_pkg::strobe_t              stb,
  output logic                          zeroData,
  output logic                          loadQ,
  output logic                          validQ,
  output logic [lsx_pkg::CAUSE_W-1:0]   causeQ
);
  import lsx_pkg::*;

  logic [3:0]         sizeMask;
  logic               misalign;
  logic [CAUSE_W-1:0] cause;

  assign sizeMask = 4'((1 << size) - 1);
  assign misalign = |(offset & sizeMask[OFF_W-1:0]);

  always_comb begin
    cause              = '0;
    cause[CAUSE_MISS]  = ~cacheHit;
    cause[CAUSE_ALIGN] = misalign;
    cause[CAUSE_TLB]   = tlbMiss;
    cause[CAUSE_LOCK]  = storeLock;
  end

  assign zeroData    = userMode & privData;
  assign stb.capture = inValid & ~flush;
  assign stb.clear   = flush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadQ  <= 1'b0;
      validQ <= 1'b0;
      causeQ <= '0;
    end else if (stb.clear) begin
      loadQ  <= 1'b0;
      validQ <= 1'b0;
      causeQ <= '0;
    end else begin
      loadQ  <= inValid;
      validQ <= inValid && (cause == '0);
      causeQ <= inValid ? cause : '0;
    end
  end

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (!validQ && !loadQ && causeQ == '0));

  // R7
  valid_needs_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    validQ |-> (loadQ && causeQ == '0));

  // R5
  byte_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && size == SZ_BYTE) |=> !causeQ[CAUSE_ALIGN]);

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !flush) |=> (!loadQ && causeQ == '0));

  // R6
  tlb_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && tlbMiss) |=> causeQ[CAUSE_TLB]);
endmodule

// File: rtl/lsx_top.sv
module lsx_top #(
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                flush,
  input  logic                inValid,
  input  logic [OFF_W-1:0]    addrLow,
  input  logic [1:0]          size,
  input  logic                signedLd,
  input  logic [DATA_W-1:0]   cacheWord,
  input  logic                cacheHit,
  input  logic                tlbMiss,
  input  logic                storeLock,
  input  logic                userMode,
  input  logic                privData,
  output logic                outLoad,
  output logic                outValid,
  output logic [DATA_W-1:0]   outData,
  output logic [3:0]          failCause
);
  lsx_pkg::strobe_t stb;
  logic zeroData;

  lsx_control #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .flush(flush),
    .offset(addrLow), .size(size), .cacheHit(cacheHit), .tlbMiss(tlbMiss),
    .storeLock(storeLock), .userMode(userMode), .privData(privData),
    .stb(stb), .zeroData(zeroData), .loadQ(outLoad), .validQ(outValid),
    .causeQ(failCause)
  );

  lsx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .offset(addrLow), .size(size),
    .signedLd(signedLd), .zeroData(zeroData), .word(cacheWord),
    .dataQ(outData)
  );
endmodule

// File: tb/lsx_top_tb.sv
module lsx_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0, inValid = 1'b0;
  logic [2:0]  addrLow = '0;
  logic [1:0]  size = '0;
  logic        signedLd = 1'b0;
  logic [63:0] cacheWord = '0;
  logic        cacheHit = 1'b1, tlbMiss = 1'b0, storeLock = 1'b0;
  logic        userMode = 1'b0, privData = 1'b0;
  logic        outLoad, outValid;
  logic [63:0] outData;
  logic [3:0]  failCause;

  int nRun = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  lsx_top u_dut (.*);

  function automatic logic [63:0] expData(logic [63:0] w, logic [2:0] off,
      logic [1:0] sz, logic sgn, logic um, logic pd);
    logic [63:0] s;
    s = w >> (8 * off);
    if (um && pd) return 64'd0;
    case (sz)
      2'b00:   return {{56{sgn & s[7]}},  s[7:0]};
      2'b01:   return {{48{sgn & s[15]}}, s[15:0]};
      2'b10:   return {{32{sgn & s[31]}}, s[31:0]};
      default: return s;
    endcase
  endfunction

  function automatic logic [3:0] expCause(logic [2:0] off, logic [1:0] sz,
      logic hit, logic tlb, logic lck);
    logic mis;
    mis = (off % (3'd1 << sz)) != 0;
    return {lck, tlb, mis, ~hit};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle of inputs at negedge, check results at the next negedge
  task automatic step(logic v, logic fl, logic [2:0] off, logic [1:0] sz,
      logic sgn, logic [63:0] w, logic hit, logic tlb, logic lck,
      logic um, logic pd, string tag);
    logic [3:0] ec;
    logic       acc;
    inValid = v; flush = fl; addrLow = off; size = sz; signedLd = sgn;
    cacheWord = w; cacheHit = hit; tlbMiss = tlb; storeLock = lck;
    userMode = um; privData = pd;
    acc = v && !fl;
    ec = acc ? expCause(off, sz, hit, tlb, lck) : 4'd0;
    @(negedge clk);
    chk({tag, " R8 load"}, 64'(outLoad), 64'(acc));
    chk({tag, " R6 cause"}, 64'(failCause), 64'(ec));
    chk({tag, " R7 valid"}, 64'(outValid), 64'(acc && ec == 4'd0));
    if (acc) chk({tag, " R1 data"}, outData, expData(w, off, sz, sgn, um, pd));
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #20;
    @(negedge clk);
    // R10 reset state
    chk("R10 outLoad", 64'(outLoad), 0);
    chk("R10 outValid", 64'(outValid), 0);
    chk("R10 failCause", 64'(failCause), 0);
    chk("R10 outData", outData, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 signed/unsigned extension at each width, negative top bit
    step(1, 0, 3'd5, 2'b00, 1, 64'h0000_8000_0000_0000, 1, 0, 0, 0, 0, "R2 sb");
    chk("R2 byte sign", outData, 64'hFFFF_FFFF_FFFF_FF80);
    step(1, 0, 3'd5, 2'b00, 0, 64'h0000_8000_0000_0000, 1, 0, 0, 0, 0, "R2 ub");
    chk("R2 byte zero", outData, 64'h80);
    step(1, 0, 3'd6, 2'b01, 1, 64'h9234_0000_0000_0000, 1, 0, 0, 0, 0, "R2 sh");
    chk("R2 half sign", outData, 64'hFFFF_FFFF_FFFF_9234);
    step(1, 0, 3'd4, 2'b10, 1, 64'hF000_0001_0000_0000, 1, 0, 0, 0, 0, "R2 sw");
    chk("R2 word sign", outData, 64'hFFFF_FFFF_F000_0001);
    step(1, 0, 3'd4, 2'b10, 0, 64'hF000_0001_0000_0000, 1, 0, 0, 0, 0, "R2 uw");
    chk("R2 word zero", outData, 64'h0000_0000_F000_0001);
    // R3 doubleword pass-through
    step(1, 0, 3'd0, 2'b11, 1, 64'h8123_4567_89AB_CDEF, 1, 0, 0, 0, 0, "R3");
    chk("R3 dword", outData, 64'h8123_4567_89AB_CDEF);
    // R4 privileged data zeroed, valid kept
    step(1, 0, 3'd0, 2'b11, 0, 64'hDEAD_BEEF_DEAD_BEEF, 1, 0, 0, 1, 1, "R4");
    chk("R4 zero", outData, 0);
    chk("R4 valid kept", 64'(outValid), 1);
    // R5 misaligned halfword, byte never misaligned
    step(1, 0, 3'd3, 2'b01, 0, 64'h1, 1, 0, 0, 0, 0, "R5 half");
    chk("R5 misalign bit", 64'(failCause[1]), 1);
    step(1, 0, 3'd7, 2'b00, 0, 64'h1, 1, 0, 0, 0, 0, "R5 byte");
    // R6 all causes together
    step(1, 0, 3'd2, 2'b10, 0, 64'h1, 0, 1, 1, 0, 0, "R6 all");
    chk("R6 cause all", 64'(failCause), 64'hF);
    // R9 flush with a valid load
    step(1, 1, 3'd0, 2'b11, 0, 64'h55, 1, 0, 0, 0, 0, "R9 flush");
    chk("R9 flushed", 64'(outValid), 0);
    // R8 idle
    step(0, 0, 3'd0, 2'b00, 0, 64'h0, 0, 1, 1, 0, 0, "R8 idle");

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] w;
      w = {$urandom(), $urandom()};
      step(($urandom() % 8) != 0, ($urandom() % 10) == 0,
           3'($urandom()), 2'($urandom()), 1'($urandom()), w,
           ($urandom() % 4) != 0, ($urandom() % 6) == 0,
           ($urandom() % 6) == 0, 1'($urandom()), ($urandom() % 4) == 0,
           "rand");
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule